// File: doc/BRIEF.md
# Write-Leveling Tap Search Engine

This block is a hardware sequencer that finds the write strobe delay for every byte lane of a DDR memory interface. It handles the lanes one at a time. For each lane it first resets the lane's delay line. It then steps the delay line one tap at a time across the usable range. At every tap it fires a burst of leveling strobes and counts how often the returned DQ feedback bit reads one. A tap reads one when the ones outnumber the zeros.

While it scans, the engine tracks runs of consecutive taps that read one and keeps the longest run. When the scan of a lane ends, it resets the lane's delay again and issues increment pulses until the delay equals the start of the longest run. The result goes into a per-lane result register. If no run qualifies, a per-lane flag is set.

The usable range is the full delay range minus a half-cycle offset, which is supplied on an input when calibration starts. A one-hot lane select is driven only while a reset or increment pulse is active, so the delay lines of the other lanes are never disturbed.

Top module: `wl_tap_search`

## Requirements
- R1: At each tap the engine issues exactly NUM_STROBES leveling strobes, one per strobe cycle. `dq_sample_i` is sampled in the cycle after each strobe. The tap reads one only when the count of ones is strictly greater than the count of zeros, so a 64/64 split out of 128 reads zero.
- R2: `half_offset_i` is captured on `start_i`. The number of taps scanned per lane is TAP_RANGE minus that offset, covering taps 0 and upward. An offset of TAP_RANGE or more scans no taps and issues no strobes.
- R3: An open run of ones closes either at a tap that reads zero or at the last scanned tap. The length of the run is the index of the closing tap minus the start index. A run that opens on the last tap never closes.
- R4: A closing run replaces the best run only if its length is strictly greater than the best so far. Of several runs of equal length, the earliest one is kept.
- R5: The result for each lane is the start tap of the best run. The result is left in the lane's delay line by one delay reset followed by exactly that many increment pulses. It is also reported on `lane_delay_o`, where lane i occupies bits [i*TW +: TW].
- R6: `lane_sel_o` has exactly one bit set, the bit of the lane being calibrated, in every cycle where `dly_rst_o` or `dly_inc_o` is high. It is all zero in every other cycle.
- R7: Lanes are calibrated in ascending order. Each lane receives exactly two delay resets per calibration: one that opens its scan and one that opens the apply phase. Strobes occur only between these two resets.
- R8: When no run closes with nonzero length, the lane's result is 0 and its bit of `no_window_o` is 1. Otherwise that bit is 0, even when the result is 0.
- R9: After every delay reset or increment pulse, at least SETTLE_CYC cycles pass with no pulse and no strobe before the next strobe.
- R10: After reset all outputs are zero. `busy_o` is high from the cycle after `start_i` until the calibration ends. `done_o` is a single-cycle pulse at the end, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a calibration of all lanes when the engine is idle |
| half_offset_i | input | TW | Half-cycle tap offset subtracted from TAP_RANGE |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse when all lanes are finished |
| lane_sel_o | output | NUM_LANES | One-hot lane select, valid only during a delay pulse |
| dly_rst_o | output | 1 | Delay reset pulse for the selected lane |
| dly_inc_o | output | 1 | Delay increment pulse for the selected lane |
| lvl_strobe_o | output | 1 | Leveling strobe pulse |
| dq_sample_i | input | 1 | DQ feedback bit, sampled one cycle after a strobe |
| lane_delay_o | output | NUM_LANES*TW | Chosen start tap per lane |
| no_window_o | output | NUM_LANES | Per-lane flag: no run of ones was found |

## Verification
A miscounted vote or a wrong run-tracker update shows up as a wrong value on `lane_delay_o` or `no_window_o` at the end of that lane. It also shows up as a wrong number of increment pulses during the apply phase, which the bench counts through its own model of each delay line. The tap patterns are chosen so that each such fault moves the visible answer: two runs of equal length, a 64/65 vote split, a run ending at the last tap, a single open tap at the end, and a run starting at tap 0. Faults in pulse sequencing, such as a stray select bit, a short settle gap, a strobe count other than 128, or lanes in the wrong order, are caught in the cycle they occur and reported at the end of that run.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LRST, S_SETTLE, S_STROBE, S_SAMPLE, S_DECIDE,
    S_INC, S_ARST, S_AGAP, S_AINC, S_NEXT, S_DONE
  } wl_state_e;
endpackage

// File: rtl/wl_vote.sv
module wl_vote #(
  parameter int NUM_STROBES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic smp_en_i,
  input  logic smp_bit_i,
  output logic last_smp_o,
  output logic tap_one_o
);
  localparam int CW = $clog2(NUM_STROBES + 1);

  logic [CW-1:0] cnt_q, cnt_d, ones_q, ones_d;
  logic [CW:0]   dbl;

  always_comb begin
    cnt_d  = cnt_q;
    ones_d = ones_q;
    if (clr_i) begin
      cnt_d  = '0;
      ones_d = '0;
    end else if (smp_en_i) begin
      cnt_d  = cnt_q + CW'(1);
      ones_d = ones_q + CW'(smp_bit_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ones_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
    end
  end

  assign last_smp_o = smp_en_i && (cnt_q == CW'(NUM_STROBES - 1));
  assign dbl        = {ones_q, 1'b0};
  assign tap_one_o  = dbl > (CW+1)'(NUM_STROBES);

  AST_ONES_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= cnt_q); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NUM_STROBES)); // R1
endmodule

// File: rtl/wl_run_track.sv
module wl_run_track #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [TW-1:0] tap_idx_i,
  input  logic          tap_one_i,
  input  logic          is_last_i,
  output logic [TW-1:0] best_start_o,
  output logic          found_o
);
  logic          act_q, act_d;
  logic [TW-1:0] st_q, st_d, bs_q, bs_d, bl_q, bl_d, len;

  always_comb begin
    act_d = act_q;
    st_d  = st_q;
    bs_d  = bs_q;
    bl_d  = bl_q;
    len   = tap_idx_i - st_q;
    if (clr_i) begin
      act_d = 1'b0;
      st_d  = '0;
      bs_d  = '0;
      bl_d  = '0;
    end else if (upd_i) begin
      if (act_q) begin
        if (!tap_one_i || is_last_i) begin
          act_d = 1'b0;
          if (len > bl_q) begin
            bs_d = st_q;
            bl_d = len;
          end
        end
      end else if (tap_one_i) begin
        act_d = 1'b1;
        st_d  = tap_idx_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      st_q  <= '0;
      bs_q  <= '0;
      bl_q  <= '0;
    end else begin
      act_q <= act_d;
      st_q  <= st_d;
      bs_q  <= bs_d;
      bl_q  <= bl_d;
    end
  end

  assign best_start_o = bs_q;
  assign found_o      = bl_q != '0;

  AST_BEST_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> bl_q >= $past(bl_q)); // R4
  AST_NO_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !found_o |-> bs_q == '0); // R8
endmodule

// File: rtl/wl_tap_search.sv
module wl_tap_search
  import wl_pkg::*;
#(
  parameter int NUM_LANES   = 2,
  parameter int TAP_RANGE   = 32,
  parameter int NUM_STROBES = 128,
  parameter int SETTLE_CYC  = 3,
  localparam int TW = $clog2(TAP_RANGE + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [TW-1:0]           half_offset_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NUM_LANES-1:0]    lane_sel_o,
  output logic                    dly_rst_o,
  output logic                    dly_inc_o,
  output logic                    lvl_strobe_o,
  input  logic                    dq_sample_i,
  output logic [NUM_LANES*TW-1:0] lane_delay_o,
  output logic [NUM_LANES-1:0]    no_window_o
);
  localparam int LW  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int SCW = $clog2(SETTLE_CYC + 2);

  wl_state_e                     state_q, state_d;
  logic [LW-1:0]                 lane_q, lane_d;
  logic [TW-1:0]                 tap_q, tap_d, ntaps_q, ntaps_d, acnt_q, acnt_d;
  logic [SCW-1:0]                settle_q, settle_d, since_q;
  logic [NUM_LANES-1:0][TW-1:0]  res_q, res_d;
  logic [NUM_LANES-1:0]          nowin_q, nowin_d;
  logic smp_en, vclr, rclr, rupd, last_smp, tap_one, found, is_last;
  logic [TW-1:0] best_start;

  assign is_last = (tap_q == ntaps_q - TW'(1));

  wl_vote #(.NUM_STROBES(NUM_STROBES)) u_vote (
    .clk(clk), .rst_n(rst_n), .clr_i(vclr), .smp_en_i(smp_en),
    .smp_bit_i(dq_sample_i), .last_smp_o(last_smp), .tap_one_o(tap_one));

  wl_run_track #(.TW(TW)) u_run (
    .clk(clk), .rst_n(rst_n), .clr_i(rclr), .upd_i(rupd), .tap_idx_i(tap_q),
    .tap_one_i(tap_one), .is_last_i(is_last), .best_start_o(best_start),
    .found_o(found));

  always_comb begin
    state_d = state_q;  lane_d = lane_q;  tap_d = tap_q;  ntaps_d = ntaps_q;
    settle_d = settle_q; acnt_d = acnt_q; res_d = res_q; nowin_d = nowin_q;
    dly_rst_o = 1'b0; dly_inc_o = 1'b0; lvl_strobe_o = 1'b0;
    smp_en = 1'b0; vclr = 1'b0; rclr = 1'b0; rupd = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        ntaps_d = (half_offset_i >= TW'(TAP_RANGE)) ? '0 : TW'(TAP_RANGE) - half_offset_i;
        lane_d  = '0;
        state_d = S_LRST;
      end
      S_LRST: begin
        dly_rst_o = 1'b1; vclr = 1'b1; rclr = 1'b1;
        tap_d = '0; settle_d = SCW'(SETTLE_CYC); state_d = S_SETTLE;
      end
      S_SETTLE: begin
        if (settle_q <= SCW'(1)) state_d = (ntaps_q == '0) ? S_ARST : S_STROBE;
        else settle_d = settle_q - SCW'(1);
      end
      S_STROBE: begin lvl_strobe_o = 1'b1; state_d = S_SAMPLE; end
      S_SAMPLE: begin smp_en = 1'b1; state_d = last_smp ? S_DECIDE : S_STROBE; end
      S_DECIDE: begin rupd = 1'b1; state_d = is_last ? S_ARST : S_INC; end
      S_INC: begin
        dly_inc_o = 1'b1; vclr = 1'b1; tap_d = tap_q + TW'(1);
        settle_d = SCW'(SETTLE_CYC); state_d = S_SETTLE;
      end
      S_ARST: begin
        dly_rst_o = 1'b1; acnt_d = '0;
        res_d[lane_q] = best_start; nowin_d[lane_q] = ~found; state_d = S_AGAP;
      end
      S_AGAP: state_d = (acnt_q == res_q[lane_q]) ? S_NEXT : S_AINC;
      S_AINC: begin dly_inc_o = 1'b1; acnt_d = acnt_q + TW'(1); state_d = S_AGAP; end
      S_NEXT: begin
        if (lane_q == LW'(NUM_LANES - 1)) state_d = S_DONE;
        else begin lane_d = lane_q + LW'(1); state_d = S_LRST; end
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; lane_q <= '0; tap_q <= '0; ntaps_q <= '0;
      settle_q <= '0; acnt_q <= '0; res_q <= '0; nowin_q <= '0;
    end else begin
      state_q <= state_d; lane_q <= lane_d; tap_q <= tap_d; ntaps_q <= ntaps_d;
      settle_q <= settle_d; acnt_q <= acnt_d; res_q <= res_d; nowin_q <= nowin_d;
    end
  end

  assign lane_sel_o   = (dly_rst_o || dly_inc_o) ? (NUM_LANES'(1) << lane_q) : '0;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign lane_delay_o = res_q;
  assign no_window_o  = nowin_q;

  // Checker-side gap counter since the last delay pulse (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= '0;
    else if (dly_rst_o || dly_inc_o) since_q <= '0;
    else if (since_q != SCW'(SETTLE_CYC + 1)) since_q <= since_q + SCW'(1);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_rst_o || dly_inc_o) |-> $countones(lane_sel_o) == 1); // R6
  AST_SEL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_rst_o || dly_inc_o) |-> lane_sel_o == '0); // R6
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_strobe_o |-> since_q >= SCW'(SETTLE_CYC)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R10
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lvl_strobe_o, dly_rst_o, dly_inc_o}) <= 1); // R9
endmodule

// File: tb/wl_tap_search_test.sv
module wl_tap_search_test;
  localparam int NL = 2, TR = 32, NS = 128, SC = 3;
  localparam int TW = $clog2(TR + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dq = 1'b0;
  logic [TW-1:0] half_offset = '0;
  logic busy, done, dly_rst, dly_inc, lvl_strobe;
  logic [NL-1:0] lane_sel, no_window;
  logic [NL*TW-1:0] lane_delay;

  always #10 clk = ~clk;

  wl_tap_search #(.NUM_LANES(NL), .TAP_RANGE(TR), .NUM_STROBES(NS), .SETTLE_CYC(SC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .half_offset_i(half_offset),
    .busy_o(busy), .done_o(done), .lane_sel_o(lane_sel), .dly_rst_o(dly_rst),
    .dly_inc_o(dly_inc), .lvl_strobe_o(lvl_strobe), .dq_sample_i(dq),
    .lane_delay_o(lane_delay), .no_window_o(no_window));

  typedef struct {int dly; int nw;} exp_t;
  exp_t sbq[$];
  int ones_tbl[NL][TR];
  int pos[NL], rst_cnt[NL], taps_seen[NL];
  int strobe_k, cur_lane, since, next_lane, cur_ntaps;
  bit bad_settle, bad_sel, bad_order, bad_strobes, bad_phase, run_done, finished;
  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_calc(input int l, input int n, output int st, output int nw);
    int active = 0, rs = 0, bs = 0, bl = 0, len;
    bit v;
    for (int j = 0; j < n; j++) begin
      v = (ones_tbl[l][j] * 2) > NS;
      if (active != 0) begin
        if (!v || j == n - 1) begin
          active = 0;
          len = j - rs;
          if (len > bl) begin bs = rs; bl = len; end
        end
      end else if (v) begin
        active = 1; rs = j;
      end
    end
    st = bs;
    nw = (bl == 0) ? 1 : 0;
  endfunction

  task automatic clear_tbl();
    for (int l = 0; l < NL; l++) for (int t = 0; t < TR; t++) ones_tbl[l][t] = 0;
  endtask

  task automatic fill(input int l, input int lo, input int hi, input int v);
    for (int t = lo; t <= hi; t++) ones_tbl[l][t] = v;
  endtask

  // Monitor: delay-line model, DQ responder, scoreboard compare.
  always @(negedge clk) begin
    if (!rst_n) dq = 1'b0;
    else begin
      if (dly_rst || dly_inc) begin
        since = 0;
        if ($countones(lane_sel) != 1) bad_sel = 1;
        for (int l = 0; l < NL; l++) if (lane_sel[l]) begin
          if (dly_rst) begin
            if (rst_cnt[l] == 1 && cur_ntaps > 0 && strobe_k != NS) bad_strobes = 1;
            if (rst_cnt[l] == 0) begin
              if (l != next_lane) bad_order = 1;
              next_lane++;
              cur_lane = l;
            end
            rst_cnt[l]++;
            pos[l] = 0;
          end else begin
            if (rst_cnt[l] == 1 && strobe_k != NS) bad_strobes = 1;
            pos[l]++;
          end
          strobe_k = 0;
        end
      end else begin
        since++;
        if (lane_sel != '0) bad_sel = 1;
      end
      if (lvl_strobe) begin
        if (since < SC + 1) bad_settle = 1;
        if (rst_cnt[cur_lane] != 1 || pos[cur_lane] >= TR) begin
          bad_phase = 1;
          dq = 1'b0;
        end else begin
          dq = (strobe_k < ones_tbl[cur_lane][pos[cur_lane]]);
          if (pos[cur_lane] + 1 > taps_seen[cur_lane]) taps_seen[cur_lane] = pos[cur_lane] + 1;
        end
        strobe_k++;
      end
      if (done) begin
        for (int l = 0; l < NL; l++) begin
          exp_t e;
          if (sbq.size() == 0) begin
            chk(1'b0, "R5 scoreboard empty", 0, 1);
          end else begin
            e = sbq.pop_front();
            chk(int'(lane_delay[l*TW +: TW]) == e.dly, "R5 result", int'(lane_delay[l*TW +: TW]), e.dly);
            chk(int'(no_window[l]) == e.nw, "R8 no_window", int'(no_window[l]), e.nw);
            chk(pos[l] == e.dly, "R5 applied delay", pos[l], e.dly);
          end
          chk(rst_cnt[l] == 2, "R7 resets per lane", rst_cnt[l], 2);
          chk(taps_seen[l] == cur_ntaps, "R2 taps scanned", taps_seen[l], cur_ntaps);
        end
        chk(!bad_sel, "R6 select", int'(bad_sel), 0);
        chk(!bad_settle, "R9 settle", int'(bad_settle), 0);
        chk(!bad_order, "R7 lane order", int'(bad_order), 0);
        chk(!bad_strobes, "R1 strobes per tap", int'(bad_strobes), 0);
        chk(!bad_phase, "R7 strobe phase", int'(bad_phase), 0);
        run_done = 1;
      end
    end
  end

  task automatic run_case(input int offset);
    int st, nw;
    cur_ntaps = (offset >= TR) ? 0 : TR - offset;
    for (int l = 0; l < NL; l++) begin
      ref_calc(l, cur_ntaps, st, nw);
      sbq.push_back('{dly: st, nw: nw});
      pos[l] = 0; rst_cnt[l] = 0; taps_seen[l] = 0;
    end
    bad_settle = 0; bad_sel = 0; bad_order = 0; bad_strobes = 0; bad_phase = 0;
    next_lane = 0; cur_lane = 0; strobe_k = 0; since = 100; run_done = 0;
    @(negedge clk);
    half_offset = TW'(offset);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    half_offset = '1;  // later changes must not matter (R2: captured on start)
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    wait (run_done);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10 idle after done", int'({busy, done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, dly_rst, dly_inc, lvl_strobe} == 5'b0, "R10 reset controls",
        int'({busy, done, dly_rst, dly_inc, lvl_strobe}), 0);
    chk(lane_sel == '0 && lane_delay == '0 && no_window == '0, "R10 reset outputs",
        int'(lane_delay), 0);

    // Longer second run wins; empty lane flags no window (R4, R8)
    clear_tbl(); fill(0, 3, 5, 100); fill(0, 10, 17, 128);
    run_case(8);
    // Equal runs keep earliest; 64 of 128 reads zero, 65 reads one (R4, R1)
    clear_tbl(); fill(0, 2, 4, 90); fill(0, 8, 10, 90);
    fill(1, 0, 23, 64); fill(1, 5, 7, 65);
    run_case(8);
    // Run closed by last tap; run opened on last tap never closes (R3)
    clear_tbl(); fill(0, 18, 23, 128); fill(1, 23, 23, 128);
    run_case(8);
    // Offset at or beyond range: nothing scanned (R2)
    clear_tbl(); fill(0, 0, 31, 128);
    run_case(32);
    run_case(40);
    // Full range; result 0 with a window present, single-tap run (R8, R3)
    clear_tbl(); fill(0, 0, 30, 128); fill(1, 1, 1, 128);
    run_case(0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule